// File: doc/BRIEF.md
# Token-Chain Readout Word Sender

This block is one station on a readout chain in which an active-low enable token is handed from device to device. While the token is held at its input and readout is switched on, the block puts a programmed number of 16-bit words on its data output, one word per strobe from the collector. Once the last word is out, it asserts its own outgoing token so the next station can start. When readout is switched off, the incoming token is wired straight through to the outgoing token.

Two words are available. Word 0 is a frozen snapshot of a four-tick history of four channel outputs, taken on a capture pulse. Word 1 is the transfer number as it stands at that moment, with no history delay. Any word index past these two reads as zero. A terminal-count register holds the word count and the enable bit. The current word count and a three-bit state vector can be read at any time.

Top module: `hsro_chain_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the terminal-count register, the current count, the history and the snapshot are all zero. Readout is off, so the outgoing token follows the incoming token.
- R2: While term_reg bit 15 is 0, tok_out_n equals tok_in_n in the same cycle, and data_en stays low.
- R3: A cycle with cfg_wr high loads the terminal-count register at the next edge. Bit 15 (enable) and bits 3:0 (word count) are kept. Bits 14:4 always read back as zero.
- R4: In the cycle after tok_in_n is high, cur_count is zero. In the cycle after a cycle with tok_in_n low, data_en high and word_stb high, cur_count is one more than before. Otherwise it holds.
- R5: With readout on, tok_out_n is low exactly while tok_in_n is low and cur_count equals the terminal count. It stays low until tok_in_n goes high.
- R6: data_en is high exactly while readout is on, tok_in_n is low and cur_count differs from the terminal count. data_en and an active outgoing token never coincide.
- R7: Word 0 (cur_count = 0) is the snapshot. Bits 4k+3:4k hold channels 3..0 at history stage k. Stage 0 is the oldest tick (T-1) and stage 3 the newest (T+2). Each tick_en pulse shifts chan_in into stage 3 and moves every stage one step toward stage 0.
- R8: Word 1 (cur_count = 1) is xfer_num as presented in the same cycle.
- R9: Any word index of 2 or more reads as zero. rd_data is zero whenever data_en is low.
- R10: hsro_state bit 0 is tok_in_n, bit 1 is tok_out_n and bit 2 is data_en.
- R11: When snap_en and tick_en are high in the same cycle, the snapshot takes the history as it was before that cycle's shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_in_n | input | 1 | Incoming chain token, active low |
| word_stb | input | 1 | Collector strobe: one word is taken per strobe while data_en is high |
| tick_en | input | 1 | Shifts a new channel sample into the history |
| chan_in | input | 4 | Channel output bits for the current tick |
| snap_en | input | 1 | Freezes the history into the word-0 snapshot |
| xfer_num | input | 16 | Live transfer number, sent as word 1 |
| cfg_wr | input | 1 | Write strobe for the terminal-count register |
| cfg_wdata | input | 16 | Write data: bit 15 enable, bits 3:0 word count |
| term_reg | output | 16 | Terminal-count register readback |
| cur_count | output | 4 | Words sent since the token arrived |
| hsro_state | output | 3 | {data_en, tok_out_n, tok_in_n} |
| tok_out_n | output | 1 | Outgoing chain token, active low |
| data_en | output | 1 | Block is driving a valid word |
| rd_data | output | 16 | Word selected by cur_count, zero when idle |

## Verification
The hardest case to reach is a sample tick and a capture pulse landing in the same cycle, followed by a readout of word 0. This is the only path that shows whether the snapshot caught the pre-shift history. The stimulus first loads four distinct nibbles, then fires both pulses together with a fifth, new nibble and opens the token so the frozen word can be compared. A second hard case is a terminal-count rewrite while the token is held. The random phase brings this about by writing configuration in the middle of a transfer and letting the reference model follow the comparator.

// File: rtl/hsro_pkg.sv
// Shared constants for the chain readout controller.
// Assumes a 16-bit register width with the enable flag in the top bit.
package hsro_pkg;
    localparam int WORD_W     = 16;
    localparam int TERM_EN_B  = WORD_W - 1;

    // Word index values the selector decodes.
    typedef enum logic [1:0] {
        WSEL_HIST = 2'd0,
        WSEL_XFER = 2'd1
    } wsel_e;
endpackage

// File: rtl/hsro_history.sv
// Channel history pipeline and snapshot latch.
// Stage 0 is the oldest tick and the top stage the newest. The snapshot
// takes the pipeline's registered value, so a capture in the same cycle
// as a shift sees the pre-shift contents.
module hsro_history #(
    parameter int NCHAN = 4,
    parameter int NTICK = 4,
    localparam int SNAP_W = NCHAN * NTICK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              snap_en,
    input  logic [NCHAN-1:0]  chan_in,
    output logic [SNAP_W-1:0] snap
);
    logic [NCHAN-1:0]  stage [NTICK];
    logic [SNAP_W-1:0] flat;

    for (genvar g = 0; g < NTICK; g++) begin : g_stage
        // Shift one stage toward the oldest end on each tick.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[g] <= '0;
            else if (tick_en)
                stage[g] <= (g == NTICK - 1) ? chan_in : stage[(g + 1) % NTICK];
        end
        assign flat[g*NCHAN +: NCHAN] = stage[g];
    end

    // Freeze the history into the readout snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (snap_en)
            snap <= flat;
    end
endmodule

// File: rtl/hsro_token_ctrl.sv
// Word counter and terminal-count comparator that produce the data
// enable and the outgoing token. Assumes a nonzero terminal count while
// enabled. With the enable off, the token passes through combinationally.
module hsro_token_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] term_cnt,
    input  logic             tok_in_n,
    input  logic             word_stb,
    output logic [CNT_W-1:0] count,
    output logic             data_en,
    output logic             tok_out_n
);
    logic at_term;
    logic tok_act;

    // Compare the words sent against the programmed count.
    always_comb begin
        at_term   = (count == term_cnt);
        tok_act   = !tok_in_n;
        data_en   = enable && tok_act && !at_term;
        tok_out_n = enable ? !(tok_act && at_term) : tok_in_n;
    end

    // Clear the counter while the token is away; step it on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tok_in_n)
            count <= '0;
        else if (data_en && word_stb)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/hsro_word_sel.sv
// Chooses the readout word from the current word index.
// Assumes the snapshot is no wider than the data word.
module hsro_word_sel
    import hsro_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4,
    parameter int SNAP_W = 16
) (
    input  logic [CNT_W-1:0]  idx,
    input  logic              data_en,
    input  logic [SNAP_W-1:0] snap,
    input  logic [DATA_W-1:0] xfer,
    output logic [DATA_W-1:0] rd_data
);
    // Return history, transfer number or zero by index.
    always_comb begin
        rd_data = '0;
        if (data_en) begin
            if (idx == CNT_W'(WSEL_HIST))
                rd_data = DATA_W'(snap);
            else if (idx == CNT_W'(WSEL_XFER))
                rd_data = xfer;
        end
    end
endmodule

// File: rtl/hsro_chain_ctrl.sv
// Top of the chain readout controller: holds the terminal-count register
// and ties together the history, the counter/comparator and the selector.
// Assumes software writes a nonzero word count whenever it sets the enable.
module hsro_chain_ctrl
    import hsro_pkg::*;
#(
    parameter int NCHAN  = 4,
    parameter int NTICK  = 4,
    parameter int DATA_W = WORD_W,
    parameter int CNT_W  = 4,
    localparam int SNAP_W = NCHAN * NTICK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in_n,
    input  logic              word_stb,
    input  logic              tick_en,
    input  logic [NCHAN-1:0]  chan_in,
    input  logic              snap_en,
    input  logic [DATA_W-1:0] xfer_num,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] term_reg,
    output logic [CNT_W-1:0]  cur_count,
    output logic [2:0]        hsro_state,
    output logic              tok_out_n,
    output logic              data_en,
    output logic [DATA_W-1:0] rd_data
);
    logic             term_en;
    logic [CNT_W-1:0] term_cnt;
    logic [SNAP_W-1:0] snap;
    logic             unused_wbits;

    assign unused_wbits = ^cfg_wdata[DATA_W-2:CNT_W];

    // Load the enable flag and word count from a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_en  <= 1'b0;
            term_cnt <= '0;
        end else if (cfg_wr) begin
            term_en  <= cfg_wdata[DATA_W-1];
            term_cnt <= cfg_wdata[CNT_W-1:0];
        end
    end

    // Present the register with unallocated bits reading zero.
    always_comb begin
        term_reg = '0;
        term_reg[DATA_W-1]  = term_en;
        term_reg[CNT_W-1:0] = term_cnt;
    end

    hsro_history #(.NCHAN(NCHAN), .NTICK(NTICK)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .snap_en (snap_en),
        .chan_in (chan_in),
        .snap    (snap)
    );

    hsro_token_ctrl #(.CNT_W(CNT_W)) u_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (term_en),
        .term_cnt  (term_cnt),
        .tok_in_n  (tok_in_n),
        .word_stb  (word_stb),
        .count     (cur_count),
        .data_en   (data_en),
        .tok_out_n (tok_out_n)
    );

    hsro_word_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_sel (
        .idx     (cur_count),
        .data_en (data_en),
        .snap    (snap),
        .xfer    (xfer_num),
        .rd_data (rd_data)
    );

    assign hsro_state = {data_en, tok_out_n, tok_in_n};
endmodule

// File: rtl/hsro_chain_ctrl_chk.sv
// Protocol checks for the chain readout controller, bound to its top.
module hsro_chain_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_in_n,
    input logic              word_stb,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] term_reg,
    input logic [CNT_W-1:0]  cur_count,
    input logic              tok_out_n,
    input logic              data_en,
    input logic [DATA_W-1:0] rd_data
);
    // R2: with readout off the token passes through unchanged.
    p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !term_reg[DATA_W-1] |-> (tok_out_n == tok_in_n));

    // R4: a released token clears the count.
    p_count_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tok_in_n |=> (cur_count == '0));

    // R4: an accepted word advances the count by one.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_in_n && data_en && word_stb) |=> (cur_count == $past(cur_count) + 1'b1));

    // R5: an asserted outgoing token holds until the incoming one is released.
    p_token_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term_reg[DATA_W-1] && !tok_in_n && !tok_out_n && !cfg_wr) |=> (tok_in_n || !tok_out_n));

    // R6: never drive data while passing the token on.
    p_enable_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> tok_out_n);

    // R9: the data output is quiet whenever no word is enabled.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |-> (rd_data == '0));
endmodule

bind hsro_chain_ctrl hsro_chain_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in_n  (tok_in_n),
    .word_stb  (word_stb),
    .cfg_wr    (cfg_wr),
    .term_reg  (term_reg),
    .cur_count (cur_count),
    .tok_out_n (tok_out_n),
    .data_en   (data_en),
    .rd_data   (rd_data)
);

// File: tb/test_hsro_chain_ctrl.sv
`timescale 1ns/100ps
module test_hsro_chain_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_in_n = 1'b1, word_stb = 1'b0, tick_en = 1'b0, snap_en = 1'b0, cfg_wr = 1'b0;
    logic [3:0]  chan_in = '0;
    logic [15:0] xfer_num = '0, cfg_wdata = '0;
    logic [15:0] term_reg, rd_data;
    logic [3:0]  cur_count;
    logic [2:0]  hsro_state;
    logic        tok_out_n, data_en;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    bit       m_en;
    int       m_term, m_cnt;
    logic [3:0]  m_hist[$];
    logic [15:0] m_snap;

    always #2 clk = ~clk;

    hsro_chain_ctrl i_hsro_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_in_n(tok_in_n), .word_stb(word_stb),
        .tick_en(tick_en), .chan_in(chan_in), .snap_en(snap_en), .xfer_num(xfer_num),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .term_reg(term_reg), .cur_count(cur_count),
        .hsro_state(hsro_state), .tok_out_n(tok_out_n), .data_en(data_en), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pack_hist();
        logic [15:0] v = '0;
        for (int k = 0; k < 4; k++) v[4*k +: 4] = m_hist[k];
        return v;
    endfunction

    task automatic model_reset();
        m_en = 0; m_term = 0; m_cnt = 0; m_snap = '0;
        m_hist = {4'h0, 4'h0, 4'h0, 4'h0};
    endtask

    // Compare all outputs mid-cycle, advance the model, wait for next negedge.
    task automatic cyc();
        bit act, eden, etok;
        logic [15:0] edata, eterm;
        #1;
        act   = !tok_in_n;
        etok  = m_en ? !(act && m_cnt == m_term) : tok_in_n;
        eden  = m_en && act && (m_cnt != m_term);
        edata = !eden ? 16'h0 : (m_cnt == 0) ? m_snap : (m_cnt == 1) ? xfer_num : 16'h0;
        eterm = {m_en, 11'b0, 4'(m_term)};
        if (rst_n) begin
            chk(m_en ? "R5 token" : "R2 token", {15'b0, tok_out_n}, {15'b0, etok});
            chk("R6 data_en", {15'b0, data_en}, {15'b0, eden});
            chk(m_cnt == 0 ? "R7 R11 word0" : m_cnt == 1 ? "R8 word1" : "R9 word", rd_data, edata);
            chk("R4 count", {12'b0, cur_count}, 16'(m_cnt));
            chk("R3 term", term_reg, eterm);
            chk("R10 state", {13'b0, hsro_state}, {13'b0, eden, etok, tok_in_n});
        end
        if (!rst_n) model_reset();
        else begin
            if (tok_in_n) m_cnt = 0;
            else if (eden && word_stb) m_cnt = (m_cnt + 1) % 16;
            if (cfg_wr) begin m_en = cfg_wdata[15]; m_term = int'(cfg_wdata[3:0]); end
            if (snap_en) m_snap = pack_hist();
            if (tick_en) begin void'(m_hist.pop_front()); m_hist.push_back(chan_in); end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        word_stb = 0; tick_en = 0; snap_en = 0; cfg_wr = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        // R1: reset state
        #0.5;
        chk("R1 term", term_reg, 16'h0);
        chk("R1 count", {12'b0, cur_count}, 16'h0);
        chk("R1 token", {15'b0, tok_out_n}, 16'h1);
        cyc();
        // R2: bypass follows token both ways
        tok_in_n = 0; #0.5; chk("R2 pass low", {15'b0, tok_out_n}, 16'h0); cyc();
        tok_in_n = 1; cyc();
        // R3: only enable and count kept
        cfg_wr = 1; cfg_wdata = 16'hFFF3; cyc(); idle();
        #0.5; chk("R3 masked", term_reg, 16'h8003); cyc();
        // R7: layout; channels 0..3 single bits at successive ticks
        for (int k = 0; k < 4; k++) begin tick_en = 1; chan_in = 4'(1 << k); cyc(); end
        idle(); snap_en = 1; cyc(); idle();
        xfer_num = 16'hBEEF; tok_in_n = 0;
        #0.5; chk("R7 layout", rd_data, 16'h8421); cyc();
        word_stb = 1; cyc();
        #0.5; chk("R8 xfer", rd_data, 16'hBEEF); cyc();
        word_stb = 0; cyc(); word_stb = 1; cyc(); word_stb = 0;
        #0.5; chk("R5 done", {15'b0, tok_out_n}, 16'h0); cyc(); cyc();
        tok_in_n = 1; cyc();
        // R11: capture with a shift in the same cycle
        cfg_wr = 1; cfg_wdata = 16'h8005; cyc(); idle();
        for (int k = 1; k <= 4; k++) begin tick_en = 1; chan_in = 4'(k); cyc(); end
        tick_en = 1; snap_en = 1; chan_in = 4'h5; cyc(); idle();
        tok_in_n = 0;
        #0.5; chk("R11 pre-shift", rd_data, 16'h4321); cyc();
        // R9: words 2..4 read zero
        word_stb = 1;
        repeat (6) cyc();
        word_stb = 0; tok_in_n = 1; cyc();
        // Random phase with mid-transfer rewrites
        for (int i = 0; i < 2000; i++) begin
            tok_in_n = ($urandom_range(0, 9) < 2) ? ~tok_in_n : tok_in_n;
            word_stb = $urandom_range(0, 1);
            tick_en  = $urandom_range(0, 1);
            snap_en  = ($urandom_range(0, 7) == 0);
            chan_in  = 4'($urandom);
            xfer_num = 16'($urandom);
            cfg_wr   = ($urandom_range(0, 39) == 0);
            cfg_wdata = {1'($urandom_range(0, 3) != 0), 11'($urandom), 4'($urandom_range(1, 6))};
            cyc();
        end
        idle();
        cyc();
        summary();
    end
endmodule